// File: doc/BRIEF.md
# Soft-Stepping Stereo Digital Volume Control

This block is a two-channel gain stage for a DAC audio path. Each channel receives 16-bit signed PCM samples with a shared valid strobe. It returns each sample multiplied by the channel's applied gain, rounded and clipped to 16 bits, one clock after the input. The applied gain is never changed in one jump. It is held in 0.125 dB units and moves toward a programmable target gain by one unit per accepted sample, so a change of volume becomes a short ramp rather than a click.

A small set of control inputs chooses how the targets are formed. There are two per-channel target codes, a link mode in which the left code drives both channels, and an external volume code that is used only while a source-select bit picks it. A rate field selects one of three behaviours: full-rate ramping, half-rate ramping, or a direct jump to the target. Mute ramps the gain down to the floor and then forces silence. Each channel shows a flag that is high while its applied gain equals its current effective target.

Top module: `softvol_top`

## Requirements
- R1: A target code is an 8-bit two's complement value in 0.5 dB units. +48 means +24 dB and -127 means -63.5 dB. Codes above +48 act as +48, and code -128 acts as -127. The applied gain in 0.125 dB units stays within -508..+192.
- R2: The left and right channels have separate target codes and separate ramps. With linking off and the pin source off, the left channel follows `tgt_left` and the right channel follows `tgt_right`.
- R3: With `rate_sel` = 00, every cycle with `in_valid` high moves the applied gain exactly one 0.125 dB unit toward the effective target. A ramp from reset (-508) up to code 0 takes exactly 508 valid samples.
- R4: A phase bit is cleared by reset and toggles on every valid sample. With `rate_sel` = 01, the gain steps only on valid samples where the phase bit is 0, which gives one step per two samples.
- R5: With `rate_sel` = 10 or 11, a valid sample loads the applied gain directly with the effective target.
- R6: `done_left` and `done_right` are high exactly when the channel's applied gain equals its effective target (4 × the clamped code, or -508 under mute). They are low during a ramp.
- R7: With `mute_en` high, the effective target of both channels is -508 and the ramp uses the selected rate. A sample accepted while the gain is at -508 and mute is on produces output 0. Clearing mute ramps the gain back to the code target.
- R8: With `master_en` high, `tgt_left` drives both channels and `tgt_right` has no effect.
- R9: With `pin_sel` high, `pin_gain` drives both channels. While `pin_sel` is low, `pin_gain` has no effect.
- R10: For applied gain g, let u = g + 528, e = u / 48 and m = u mod 48. Let M = round(16384 × 2^(m/48)) and s = 25 - e. Then out = saturate16(floor((x × M + 2^(s-1)) / 2^s)).
- R11: The output is registered, and `out_valid` follows `in_valid` by one cycle. The gain and phase hold on cycles without `in_valid`. Reset sets the gain to -508 and clears the outputs and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe, shared by both channels |
| in_left | input | 16 | Left PCM sample, signed |
| in_right | input | 16 | Right PCM sample, signed |
| tgt_left | input | 8 | Left target code |
| tgt_right | input | 8 | Right target code |
| master_en | input | 1 | Left code drives both channels |
| mute_en | input | 1 | Ramp to floor, then silence |
| rate_sel | input | 2 | 00 full rate, 01 half rate, 1x jump |
| pin_sel | input | 1 | Use external volume code for both channels |
| pin_gain | input | 8 | External volume code |
| out_valid | output | 1 | Output strobe |
| out_left | output | 16 | Scaled left sample |
| out_right | output | 16 | Scaled right sample |
| done_left | output | 1 | Left applied gain equals its target |
| done_right | output | 1 | Right applied gain equals its target |

## Verification
Two events can land on the same clock edge. The first is a gain step, or a jump in bypass mode. The second is the scaling of the sample that arrives with it. The design must scale that sample with the gain held before the step, and the bench model follows the same order. The bench changes targets, mute and rate while samples keep streaming, and it also lets the strobe drop for single cycles. A gain that is read one step early or late would change the rounded product, so comparing every output word against the model shows which gain was used.

// File: rtl/softvol_pkg.sv
package softvol_pkg;
  localparam int SAMPLE_W   = 16;
  localparam int GAIN_W     = 10;
  localparam int CODE_W     = 8;
  localparam int MANT_N     = 48;
  localparam int MANT_FRAC  = 14;
  localparam int CODE_MAX   = 48;
  localparam int CODE_MIN   = -127;
  localparam logic signed [GAIN_W-1:0] GAIN_FLOOR = GAIN_W'(CODE_MIN * 4);
  localparam logic signed [GAIN_W-1:0] GAIN_CEIL  = GAIN_W'(CODE_MAX * 4);
  // offset that makes the gain index non-negative, a whole number of 6 dB spans
  localparam int OCT_BELOW  = (-(CODE_MIN * 4) + MANT_N - 1) / MANT_N;
  localparam int GAIN_OFS   = OCT_BELOW * MANT_N;
  localparam int BASE_SHIFT = MANT_FRAC + OCT_BELOW;
  localparam int PROD_W     = 48;

  typedef logic [15:0] mant_tab_t [MANT_N];

  function automatic mant_tab_t build_mant_tab();
    mant_tab_t t;
    for (int i = 0; i < MANT_N; i++) begin
      t[i] = 16'($rtoi(real'(1 << MANT_FRAC) * (2.0 ** (real'(i) / real'(MANT_N))) + 0.5));
    end
    return t;
  endfunction

  // 8-bit code in 0.5 dB units -> gain in 0.125 dB units, clamped
  function automatic logic signed [GAIN_W-1:0] code_to_gain(logic signed [CODE_W-1:0] c);
    logic signed [CODE_W-1:0] k;
    k = c;
    if (k > CODE_W'(CODE_MAX)) k = CODE_W'(CODE_MAX);
    else if (k < CODE_W'(CODE_MIN)) k = CODE_W'(CODE_MIN);
    return {k, 2'b00};
  endfunction

  function automatic logic signed [SAMPLE_W-1:0] scale_round_sat(
      logic signed [SAMPLE_W-1:0] x, logic [15:0] mant, int sh);
    logic signed [PROD_W-1:0] p;
    logic signed [PROD_W-1:0] r;
    p = $signed({{(PROD_W-SAMPLE_W){x[SAMPLE_W-1]}}, x}) *
        $signed({{(PROD_W-16){1'b0}}, mant});
    r = (p + (PROD_W'(1) <<< (sh - 1))) >>> sh;
    if (r > PROD_W'(32767)) return SAMPLE_W'(32767);
    if (r < -PROD_W'(32768)) return SAMPLE_W'(-32768);
    return r[SAMPLE_W-1:0];
  endfunction
endpackage

// File: rtl/softvol_ramp.sv
module softvol_ramp
  import softvol_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     step_ok,
  input  logic                     jump,
  input  logic signed [GAIN_W-1:0] target_q,
  output logic signed [GAIN_W-1:0] gain_q,
  output logic                     done
);
  logic below, above;
  assign below = gain_q < target_q;
  assign above = gain_q > target_q;
  assign done  = !below && !above;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_q <= GAIN_FLOOR;
    end else if (adv) begin
      if (jump)              gain_q <= target_q;
      else if (step_ok && below) gain_q <= gain_q + GAIN_W'(1);
      else if (step_ok && above) gain_q <= gain_q - GAIN_W'(1);
    end
  end

  AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_q >= GAIN_FLOOR) && (gain_q <= GAIN_CEIL)); // R1
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && step_ok && !jump && below) |=> (gain_q == $past(gain_q) + GAIN_W'(1))); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && step_ok && !jump && above) |=> (gain_q == $past(gain_q) - GAIN_W'(1))); // R3
  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && jump) |=> (gain_q == $past(target_q))); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv) |=> $stable(gain_q)); // R11
endmodule

// File: rtl/softvol_scaler.sv
module softvol_scaler
  import softvol_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       valid,
  input  logic                       zero_force,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [GAIN_W-1:0]   gain_q,
  output logic signed [SAMPLE_W-1:0] out_sample
);
  localparam mant_tab_t MANT_TAB = build_mant_tab();

  int                          u_idx;
  int                          oct;
  logic [5:0]                  frac_idx;
  logic [15:0]                 mant;
  logic signed [SAMPLE_W-1:0]  scaled;

  always_comb begin
    u_idx    = int'(gain_q) + GAIN_OFS;
    oct      = u_idx / MANT_N;
    frac_idx = 6'(u_idx % MANT_N);
    mant     = MANT_TAB[frac_idx];
    scaled   = scale_round_sat(sample, mant, BASE_SHIFT - oct);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     out_sample <= '0;
    else if (valid) out_sample <= zero_force ? '0 : scaled;
  end

  AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && zero_force) |=> (out_sample == '0)); // R7
  AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !zero_force && gain_q == '0) |=> (out_sample == $past(sample))); // R10
endmodule

// File: rtl/softvol_top.sv
module softvol_top
  import softvol_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [15:0]  in_left,
  input  logic signed [15:0]  in_right,
  input  logic [7:0]          tgt_left,
  input  logic [7:0]          tgt_right,
  input  logic                master_en,
  input  logic                mute_en,
  input  logic [1:0]          rate_sel,
  input  logic                pin_sel,
  input  logic [7:0]          pin_gain,
  output logic                out_valid,
  output logic signed [15:0]  out_left,
  output logic signed [15:0]  out_right,
  output logic                done_left,
  output logic                done_right
);
  localparam int NCH = 2;

  logic                       phase_q;
  logic                       step_ok;
  logic                       jump;
  logic [CODE_W-1:0]          code_sel [NCH];
  logic signed [GAIN_W-1:0]   tgt_q    [NCH];
  logic signed [GAIN_W-1:0]   gain     [NCH];
  logic                       done     [NCH];
  logic                       zero_f   [NCH];
  logic signed [SAMPLE_W-1:0] smp_in   [NCH];
  logic signed [SAMPLE_W-1:0] smp_out  [NCH];

  assign jump    = rate_sel[1];
  assign step_ok = (rate_sel == 2'b00) || (rate_sel == 2'b01 && !phase_q);

  assign code_sel[0] = pin_sel ? pin_gain : tgt_left;
  assign code_sel[1] = pin_sel ? pin_gain : (master_en ? tgt_left : tgt_right);
  assign smp_in[0]   = in_left;
  assign smp_in[1]   = in_right;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) phase_q <= !phase_q;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign tgt_q[ch]  = mute_en ? GAIN_FLOOR : code_to_gain(code_sel[ch]);
    assign zero_f[ch] = mute_en && (gain[ch] == GAIN_FLOOR);

    softvol_ramp u_ramp (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (in_valid),
      .step_ok  (step_ok),
      .jump     (jump),
      .target_q (tgt_q[ch]),
      .gain_q   (gain[ch]),
      .done     (done[ch])
    );

    softvol_scaler u_scale (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid      (in_valid),
      .zero_force (zero_f[ch]),
      .sample     (smp_in[ch]),
      .gain_q     (gain[ch]),
      .out_sample (smp_out[ch])
    );
  end

  assign out_left   = smp_out[0];
  assign out_right  = smp_out[1];
  assign done_left  = done[0];
  assign done_right = done[1];

  AST_HALF_RATE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rate_sel == 2'b01 && phase_q) |=> ($stable(gain[0]) && $stable(gain[1]))); // R4
  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R11
  AST_LINKED_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && !pin_sel) |-> (tgt_q[0] == tgt_q[1])); // R8
endmodule

// File: tb/softvol_top_tb_top.sv
module softvol_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, vin, master, mute, psel, out_valid, done_left, done_right;
  logic signed [15:0] xl, xr, out_left, out_right;
  logic [7:0] tl, tr, pgain;
  logic [1:0] rate;

  int checks = 0;
  int errors = 0;
  int g [2];
  bit ph;
  bit ev;
  int el, er;
  bit rnd_x = 1'b1;

  softvol_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_left(xl), .in_right(xr),
    .tgt_left(tl), .tgt_right(tr), .master_en(master), .mute_en(mute),
    .rate_sel(rate), .pin_sel(psel), .pin_gain(pgain),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .done_left(done_left), .done_right(done_right)
  );

  function automatic int mant_of(int m);
    return int'($floor(16384.0 * $exp($ln(2.0) * real'(m) / 48.0) + 0.5));
  endfunction

  function automatic int clamp_code(logic [7:0] c);
    int v;
    v = int'($signed(c));
    if (v > 48) v = 48;
    if (v < -127) v = -127;
    return v;
  endfunction

  function automatic int tgt_of(int ch);
    logic [7:0] c;
    if (psel) c = pgain;
    else if (ch == 0 || master) c = tl;
    else c = tr;
    return mute ? -508 : 4 * clamp_code(c);
  endfunction

  function automatic int exp_out(int x, int gq);
    int u, sh;
    longint p;
    if (mute && gq == -508) return 0;
    u  = gq + 528;
    sh = 25 - u / 48;
    p  = longint'(x) * longint'(mant_of(u % 48));
    p  = (p + (longint'(1) << (sh - 1))) >>> sh;
    if (p > 32767) return 32767;
    if (p < -32768) return -32768;
    return int'(p);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic signed [15:0] pick_sample();
    int k;
    k = int'($urandom_range(0, 9));
    if (k == 0) return 16'sh7fff;
    if (k == 1) return 16'sh8000;
    return 16'($urandom);
  endfunction

  // caller is at a negedge; one edge is modelled and checked
  task automatic tick();
    bit ok;
    int t;
    if (rnd_x) begin
      xl = pick_sample();
      xr = pick_sample();
    end
    ev = vin;
    if (vin) begin
      el = exp_out(int'(xl), g[0]);
      er = exp_out(int'(xr), g[1]);
      ok = (rate == 2'b00) || (rate == 2'b01 && !ph);
      for (int ch = 0; ch < 2; ch++) begin
        t = tgt_of(ch);
        if (rate[1]) g[ch] = t;
        else if (ok && g[ch] < t) g[ch] = g[ch] + 1;
        else if (ok && g[ch] > t) g[ch] = g[ch] - 1;
      end
      ph = !ph;
    end
    @(posedge clk);
    #1;
    check("R11 out_valid", int'(out_valid), int'(ev));
    if (ev) begin
      check("R10 out_left", int'(out_left), el);
      check("R10 out_right", int'(out_right), er);
    end
    check("R6 done_left", int'(done_left), int'(g[0] == tgt_of(0)));
    check("R6 done_right", int'(done_right), int'(g[1] == tgt_of(1)));
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int first;
    void'($urandom(32'd4242));
    rst_n = 1'b0; vin = 1'b0; master = 1'b0; mute = 1'b0; psel = 1'b0;
    xl = '0; xr = '0; tl = 8'd0; tr = 8'd0; pgain = 8'd0; rate = 2'b00;
    g[0] = -508; g[1] = -508; ph = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    check("R11 reset out_valid", int'(out_valid), 0);
    check("R11 reset out_left", int'(out_left), 0);
    check("R11 reset out_right", int'(out_right), 0);
    check("R6 reset done_left", int'(done_left), 0);

    // R3 full-rate ramp from the floor to 0 dB takes 508 samples
    vin = 1'b1;
    first = -1;
    for (int i = 1; i <= 560; i++) begin
      tick();
      if (first < 0 && done_left) first = i;
    end
    check("R3 ramp length", first, 508);

    // R1 clamp: code 100 acts as +48, code -128 acts as -127
    tl = 8'd100; tr = 8'h80;
    run(700);
    check("R1 clamp reached", int'(done_left && done_right), 1);

    // R2 independent targets
    tl = 8'd10; tr = 8'hec;
    run(300);

    // R4 half-rate ramp
    rate = 2'b01; tl = 8'hf0; tr = 8'd20;
    run(400);

    // R11 gaps in the strobe hold the gain
    for (int i = 0; i < 200; i++) begin
      vin = (i % 3) != 0;
      if (i == 50) tl = 8'd30;
      tick();
    end
    vin = 1'b1;

    // R5 jump mode
    rate = 2'b10; tl = 8'h88; tr = 8'd40;
    tick();
    check("R5 jump done_left", int'(done_left), 1);
    check("R5 jump done_right", int'(done_right), 1);
    rate = 2'b11; tl = 8'd0;
    run(3);

    // R7 mute ramps down, then silences; unmute ramps up
    rate = 2'b00; tr = 8'd0; mute = 1'b1;
    run(600);
    check("R7 muted silent left", int'(out_left), 0);
    mute = 1'b0;
    run(520);

    // R8 linked control: right code ignored
    master = 1'b1; tl = 8'hf6; tr = 8'd48;
    run(120);
    check("R8 right follows left", int'(done_right), 1);
    master = 1'b0;

    // R9 pin source
    pgain = 8'd12; psel = 1'b1;
    run(200);
    psel = 1'b0; pgain = 8'h90;
    run(150);

    // mixed random traffic
    for (int i = 0; i < 5000; i++) begin
      vin = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 150) == 0) tl = 8'($urandom);
      if ($urandom_range(0, 150) == 0) tr = 8'($urandom);
      if ($urandom_range(0, 300) == 0) mute = !mute;
      if ($urandom_range(0, 250) == 0) rate = 2'($urandom);
      if ($urandom_range(0, 400) == 0) master = !master;
      if ($urandom_range(0, 400) == 0) psel = !psel;
      if ($urandom_range(0, 100) == 0) pgain = 8'($urandom);
      tick();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule